// File: doc/BRIEF.md
# Dual-Modulus Divide-by-10/11 Prescaler

This block divides an incoming clock by ten or by eleven and gives one output pulse per division cycle, on a true output `q` and on its complement `q_n`. It is the front stage of a frequency synthesiser loop. A slower counter selects the ratio for each cycle through two modulus-select inputs, and either one alone can request the shorter cycle. A control pin that nobody drives is taken as low, so the default ratio is eleven.

The counter is a state machine of eleven enumerated phases: `ST_PRE` (the preset phase) and `ST_C0` to `ST_C9`. The transitions are:
- `ST_PRE` goes to `ST_C0`.
- Each `ST_Cn` goes to `ST_Cn+1`, for n from 0 to 7.
- `ST_C8` is the decision phase. It goes to `ST_PRE` when divide-by-ten is selected and to `ST_C9` otherwise.
- `ST_C9` goes to `ST_PRE`.

The output is high in `ST_PRE` and `ST_C0` to `ST_C3`, and low in `ST_C4` to `ST_C9`. The output comes from its own settable flop.

An asynchronous `preset` input puts the machine in `ST_PRE` at once. A synchronous `inhibit` input freezes the whole machine.

Top module: `dmod_prescaler`

## Requirements
- R1: When `mod_a` or `mod_b` (or both) is 1 at the decision edge, the cycle lasts 10 rising clock edges from one rising edge of `q` to the next.
- R2: When both `mod_a` and `mod_b` are 0 at the decision edge, the cycle lasts 11 rising clock edges.
- R3: The ratio is chosen only by the control values at the clock edge that leaves `ST_C8`, which is the 10th counted edge after `q` rises. A change before that edge takes effect in the current cycle. A change after it takes effect in the next cycle.
- R4: While `preset` is 1, the machine is in `ST_PRE`, `q` is 1 and `q_n` is 0. This takes effect without a clock edge and overrides `inhibit`, `mod_a` and `mod_b`.
- R5: After `preset` is released, the first rising edge of `q` comes 10 or 11 counted clock edges later, by the rule of R1 and R2.
- R6: A rising clock edge at which `inhibit` is 1 changes neither the state nor `q`.
- R7: `q_n` is always the complement of `q`.
- R8: In each cycle `q` stays high for exactly 5 counted clock edges after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided; the machine acts on its rising edge |
| mod_a | input | 1 | Modulus select; 1 requests divide-by-10 |
| mod_b | input | 1 | Second modulus select, ORed with `mod_a` |
| preset | input | 1 | Asynchronous set to `ST_PRE`, active high |
| inhibit | input | 1 | Clock hold; 1 freezes state and output |
| q | output | 1 | Divided output, one pulse per cycle |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench builds the block with its default of two modulus-select inputs. With two inputs, all four select combinations can be driven, including the case where both are high. Because the decision phase sits at `ST_C8`, the bench can place a select change on either side of the decision edge, and can hold `inhibit` across a point where `q` would otherwise rise. A scoreboard compares each period with its expected length, counting only the edges that are not inhibited. It also checks the high time at every falling edge of `q`.

// File: rtl/dmod_pkg.sv
package dmod_pkg;

    typedef enum logic [3:0] {
        ST_C0  = 4'd0,
        ST_C1  = 4'd1,
        ST_C2  = 4'd2,
        ST_C3  = 4'd3,
        ST_C4  = 4'd4,
        ST_C5  = 4'd5,
        ST_C6  = 4'd6,
        ST_C7  = 4'd7,
        ST_C8  = 4'd8,
        ST_C9  = 4'd9,
        ST_PRE = 4'd10
    } phase_t;

    // Phase in which the modulus select is examined.
    localparam phase_t DECIDE_PHASE = ST_C8;
    // Last counting phase in which the output is still high.
    localparam phase_t LAST_HIGH    = ST_C3;

    function automatic logic phase_is_high(input phase_t ph);
        return (ph == ST_PRE) || (ph <= LAST_HIGH);
    endfunction

endpackage

// File: rtl/dmod_mode_sel.sv
module dmod_mode_sel #(
    parameter int N_CTRL = 2
) (
    input  logic [N_CTRL-1:0] ctrl,
    output logic              sel_ten
);
    // Any asserted control requests the short cycle. A control that is
    // left low keeps the long cycle, which is the default.
    always_comb begin
        sel_ten = 1'b0;
        for (int i = 0; i < N_CTRL; i++) begin
            sel_ten = sel_ten | ctrl[i];
        end
    end
endmodule

// File: rtl/dmod_seq.sv
module dmod_seq
    import dmod_pkg::*;
(
    input  logic   clk,
    input  logic   preset,
    input  logic   inhibit,
    input  logic   sel_ten,
    output phase_t st,
    output phase_t st_nxt
);
    // Next-phase logic
    always_comb begin
        unique case (st)
            ST_PRE:  st_nxt = ST_C0;
            ST_C0:   st_nxt = ST_C1;
            ST_C1:   st_nxt = ST_C2;
            ST_C2:   st_nxt = ST_C3;
            ST_C3:   st_nxt = ST_C4;
            ST_C4:   st_nxt = ST_C5;
            ST_C5:   st_nxt = ST_C6;
            ST_C6:   st_nxt = ST_C7;
            ST_C7:   st_nxt = ST_C8;
            ST_C8:   st_nxt = sel_ten ? ST_PRE : ST_C9;
            ST_C9:   st_nxt = ST_PRE;
            default: st_nxt = ST_PRE;
        endcase
    end

    // State register, set asynchronously to the preset phase
    always_ff @(posedge clk or posedge preset) begin
        if (preset) begin
            st <= ST_PRE;
        end else if (!inhibit) begin
            st <= st_nxt;
        end
    end

    a_r1_skip_on_ten: assert property (@(posedge clk) disable iff (preset)
        (st == DECIDE_PHASE && sel_ten && !inhibit) |=> (st == ST_PRE));

    a_r2_full_on_eleven: assert property (@(posedge clk) disable iff (preset)
        (st == DECIDE_PHASE && !sel_ten && !inhibit) |=> (st == ST_C9));

    a_r6_hold_state: assert property (@(posedge clk) disable iff (preset)
        inhibit |=> $stable(st));

    a_r4_preset_phase: assert property (@(posedge clk)
        preset |-> (st == ST_PRE));
endmodule

// File: rtl/dmod_out.sv
module dmod_out
    import dmod_pkg::*;
(
    input  logic   clk,
    input  logic   preset,
    input  logic   inhibit,
    input  phase_t st_nxt,
    output logic   q,
    output logic   q_n
);
    // Output stage: its own settable flop, loaded from the next-phase decode
    always_ff @(posedge clk or posedge preset) begin
        if (preset) begin
            q <= 1'b1;
        end else if (!inhibit) begin
            q <= phase_is_high(st_nxt);
        end
    end

    always_comb q_n = ~q;

    a_r6_hold_out: assert property (@(posedge clk) disable iff (preset)
        inhibit |=> $stable(q));
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
    import dmod_pkg::*;
(
    input  logic clk,
    input  logic mod_a,
    input  logic mod_b,
    input  logic preset,
    input  logic inhibit,
    output logic q,
    output logic q_n
);
    localparam int N_CTRL = 2;

    logic [N_CTRL-1:0] ctrl;
    logic              sel_ten;
    phase_t            st;
    phase_t            st_nxt;

    always_comb ctrl = {mod_b, mod_a};

    dmod_mode_sel #(.N_CTRL(N_CTRL)) u_sel (
        .ctrl    (ctrl),
        .sel_ten (sel_ten)
    );

    dmod_seq u_seq (
        .clk     (clk),
        .preset  (preset),
        .inhibit (inhibit),
        .sel_ten (sel_ten),
        .st      (st),
        .st_nxt  (st_nxt)
    );

    dmod_out u_out (
        .clk     (clk),
        .preset  (preset),
        .inhibit (inhibit),
        .st_nxt  (st_nxt),
        .q       (q),
        .q_n     (q_n)
    );

    a_r8_rise_at_preset: assert property (@(posedge clk) disable iff (preset)
        $rose(q) |-> (st == ST_PRE));

    a_r8_low_phase: assert property (@(posedge clk) disable iff (preset)
        (st == ST_C4 || st == ST_C9) |-> !q);

    a_r4_out_high: assert property (@(posedge clk)
        preset |-> (q && !q_n));
endmodule

// File: tb/dmod_prescaler_tb.sv
module dmod_prescaler_tb;
    logic clk = 1'b0;
    logic mod_a = 1'b0;
    logic mod_b = 1'b0;
    logic preset = 1'b0;
    logic inhibit = 1'b0;
    logic q, q_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cnt = 0;
    logic prev_q = 1'b1;
    int exp_q[$];
    event rise_ev;
    logic sampled;

    always #10 clk = ~clk;

    dmod_prescaler u_dut (
        .clk(clk), .mod_a(mod_a), .mod_b(mod_b),
        .preset(preset), .inhibit(inhibit), .q(q), .q_n(q_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: counts edges that are not inhibited, compares at q edges
    always @(posedge clk) begin
        if (preset) cnt = 0;
        else if (!inhibit) cnt++;
    end

    always @(negedge clk) begin
        if (preset) begin
            prev_q = q;
        end else begin
            if (q && !prev_q) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1/R2 unexpected q rise", cnt, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cnt == e, (e == 10) ? "R1 period" : "R2 period", cnt, e);
                end
                check(q_n == 1'b0, "R7 q_n at rise", int'(q_n), 0);
                cnt = 0;
                -> rise_ev;
            end else if (!q && prev_q) begin
                check(cnt == 5, "R8 high time", cnt, 5);
                check(q_n == 1'b1, "R7 q_n at fall", int'(q_n), 1);
            end
            prev_q = q;
        end
    end

    task automatic wait_rise();
        @(rise_ev);
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mod(input logic a, input logic b);
        mod_a = a;
        mod_b = b;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    // Driver
    initial begin
        #2 preset = 1'b1;
        @(negedge clk);
        check(q == 1'b1 && q_n == 1'b0, "R4 preset state", int'(q), 1);
        wait_neg(3);
        check(q == 1'b1, "R4 held under clocks", int'(q), 1);

        // R5: release with both selects low
        preset = 1'b0;
        exp_q.push_back(11);
        wait_rise();

        // R1, R2: every select combination, three periods each
        for (int c = 0; c < 4; c++) begin
            set_mod(c[0], c[1]);
            for (int k = 0; k < 3; k++) exp_q.push_back((c == 0) ? 11 : 10);
            for (int k = 0; k < 3; k++) wait_rise();
        end

        // R3: select raised then dropped before the decision edge -> 11
        set_mod(1'b1, 1'b0);
        exp_q.push_back(11);
        wait_neg(4);
        set_mod(1'b0, 1'b0);
        wait_rise();

        // R3: raised just before the decision edge (in ST_C8) -> 10
        exp_q.push_back(10);
        wait_neg(9);
        set_mod(1'b0, 1'b1);
        wait_rise();

        // R3: raised after the decision edge -> this period 11, next 10
        set_mod(1'b0, 1'b0);
        exp_q.push_back(11);
        wait_neg(10);
        set_mod(1'b1, 1'b0);
        exp_q.push_back(10);
        wait_rise();
        wait_rise();

        // R6: inhibit while q would rise
        exp_q.push_back(10);
        wait_neg(9);
        inhibit = 1'b1;
        sampled = q;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(q == sampled && q == 1'b0, "R6 hold low", int'(q), 0);
        end
        inhibit = 1'b0;
        wait_rise();

        // R6: inhibit while q is high
        exp_q.push_back(10);
        wait_neg(2);
        inhibit = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(q == 1'b1, "R6 hold high", int'(q), 1);
        end
        inhibit = 1'b0;
        wait_rise();

        // R4: asynchronous preset from a low phase, overriding inhibit and select
        set_mod(1'b0, 1'b0);
        wait_neg(6);
        check(q == 1'b0, "R4 low before preset", int'(q), 0);
        inhibit = 1'b1;
        mod_a = 1'b1;
        #5 preset = 1'b1;
        #2 check(q == 1'b1 && q_n == 1'b0, "R4 immediate set", int'(q), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(q == 1'b1, "R4 set held", int'(q), 1);
        end
        preset = 1'b0;
        inhibit = 1'b0;
        mod_a = 1'b0;
        exp_q.push_back(11);
        wait_rise();

        wait_neg(3);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule